// File: doc/BRIEF.md
# Cartridge Disk Read Controller with Byte DMA

The block is a register-mapped controller for a removable-cartridge disk. Software programs three setup registers: a start memory address, a disk address made of track and sector, and a multipurpose word that holds a negated word count. It then writes a command word to the control register. The status command clears the multipurpose word. The two read commands turn the disk address into a linear byte offset and ask a disk-side storage port for that many bytes. Each byte is passed to a DMA master port that writes memory one byte per beat, at consecutive addresses.

When the transfer finishes, the block can pulse an interrupt request at a fixed level and vector. The transfer finishes when the last byte is accepted or when the storage port flags an error. The data path is a streaming pass-through with no internal buffer. A byte moves only when the storage port offers one (`dk_dat_valid`) and the memory side accepts it (`dma_ready`). Back-pressure from either side stalls the stream without losing or repeating a byte.

Top module: `cart_disk_ctrl`

## Requirements
- R1: Word writes to the address (index 1), disk address (index 2) and multipurpose (index 3) registers read back unchanged. The register index is `reg_addr[2:1]` and the control word is index 0. A control read always shows bit 0 set, shows bit 7 set while idle, and returns the other bits as last written. After reset all registers hold zero, so a control read returns 16'h0081.
- R2: A byte write (`reg_byte`=1) takes its byte from `reg_wdata[7:0]`. With `reg_addr[0]`=1 it replaces bits 15:8 of the register; with `reg_addr[0]`=0 it replaces bits 7:0. The other half keeps its old value.
- R3: A control write carries the command code in bits 3:1. Bit 7 selects execution: the command runs only when the written bit 7 is 0. With bit 7 = 1 the word is stored and nothing else happens.
- R4: Command 2, when executed, clears the multipurpose register to zero.
- R5: Commands 6 and 7, when executed, raise `dk_req_valid`. The request offset is (track*40 + sector)*256, where track is disk address bits 15:6 and sector is bits 5:0 with bit 0 forced to 0. Offset and length hold steady until `dk_req_ready`.
- R6: The request length in bytes is (65536 − multipurpose)*2.
- R7: The n-th byte of the transfer (counting from 0) goes out with `dma_addr` equal to the low MEM_AW bits of (address register + n), wrapping modulo 2^MEM_AW. `dma_byte` equals the byte taken from the storage port.
- R8: From the executing write until the cycle after completion, control bit 7 reads 0. Further read commands written during this time are ignored.
- R9: In the data phase `dma_valid` = `dk_dat_valid` and `dk_dat_ready` = `dma_ready`. A byte moves only on a cycle where both are 1. Outside the data phase both outputs stay 0.
- R10: `dk_err` high in the data phase ends the transfer. That cycle moves no byte (`dma_valid` = `dk_dat_ready` = 0), and no further bytes follow.
- R11: One cycle after the final beat or the error, `irq_pulse` is high for exactly one cycle, but only if control bit 6 is 1 at that time. `irq_level` is always 5 and `irq_vector` is always octal 254.
- R12: Executed command codes 0, 1, 3, 4 and 5 start no request and leave the multipurpose register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write |
| reg_byte | input | 1 | Write is a single byte |
| reg_addr | input | 3 | Bits 2:1 register index, bit 0 byte lane |
| reg_wdata | input | 16 | Write data (byte in 7:0) |
| reg_rdata | output | 16 | Read data of the indexed register |
| dk_req_valid | output | 1 | Storage request pending |
| dk_req_ready | input | 1 | Storage port takes the request |
| dk_req_offset | output | OFF_W (24) | Linear byte offset |
| dk_req_len | output | 18 | Byte count |
| dk_dat_valid | input | 1 | Storage byte available |
| dk_dat_ready | output | 1 | Storage byte consumed |
| dk_dat_byte | input | 8 | Storage byte |
| dk_err | input | 1 | Storage error, ends transfer |
| dma_valid | output | 1 | Memory write beat offered |
| dma_ready | input | 1 | Memory accepts the beat |
| dma_addr | output | MEM_AW | Memory byte address |
| dma_byte | output | 8 | Memory write data |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| irq_level | output | 3 | Interrupt priority level (5) |
| irq_vector | output | 9 | Interrupt vector (octal 254) |

## Verification
The bench builds the block with MEM_AW = 8 and keeps the default geometry of 40 sectors per track and 256 bytes per sector. The narrow address bus lets a short transfer cross the memory-address wrap point. The full track range, up to 1023 with sector 63 and an odd disk address, is swept through two-byte reads, and the expected offsets are computed arithmetically. Transfer lengths of 2, 32 and 256 bytes are run with and without stall patterns on both stream sides, along with an early error, a command rewritten mid-transfer, and both interrupt-enable settings.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  localparam int REG_W = 16;
  localparam int LEN_W = REG_W + 2;

  typedef enum logic [1:0] {
    RI_CTRL = 2'd0,
    RI_ADDR = 2'd1,
    RI_DISK = 2'd2,
    RI_MULT = 2'd3
  } reg_idx_t;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_DATA = 2'd2,
    XS_DONE = 2'd3
  } xfer_state_t;

  localparam logic [2:0] CMD_STATUS  = 3'd2;
  localparam logic [2:0] CMD_READ    = 3'd6;
  localparam logic [2:0] CMD_READ_NH = 3'd7;
  localparam logic [2:0] IRQ_LVL     = 3'd5;
  localparam logic [8:0] IRQ_VEC     = 9'o254;
endpackage

// File: rtl/cdc_regs.sv
module cdc_regs
  import cdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             byte_en,
  input  logic             hi_lane,
  input  reg_idx_t         idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] addr_q,
  output logic [REG_W-1:0] disk_q,
  output logic [REG_W-1:0] mult_q,
  output logic             cmd_go,
  output logic [2:0]       cmd_code
);
  localparam int NREG = 4;
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] file_q [NREG];
  logic [REG_W-1:0] cur;
  logic [REG_W-1:0] merged;
  logic             clr_mult;

  assign cur = file_q[idx];

  always_comb begin
    merged = wdata;
    if (byte_en) begin
      if (hi_lane) merged = {wdata[HALF-1:0], cur[HALF-1:0]};
      else         merged = {cur[REG_W-1:HALF], wdata[HALF-1:0]};
    end
  end

  // execution decode on the merged control word
  assign cmd_go   = wr_en && (idx == RI_CTRL) && !merged[7];
  assign cmd_code = merged[3:1];
  assign clr_mult = cmd_go && (cmd_code == CMD_STATUS);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                              file_q[g] <= '0;
      else if (wr_en && (idx == reg_idx_t'(g))) file_q[g] <= merged;
      else if (g == int'(RI_MULT) && clr_mult) file_q[g] <= '0;
    end
  end

  assign ctrl_q = file_q[RI_CTRL];
  assign addr_q = file_q[RI_ADDR];
  assign disk_q = file_q[RI_DISK];
  assign mult_q = file_q[RI_MULT];
endmodule

// File: rtl/cdc_geom.sv
module cdc_geom
  import cdc_pkg::*;
#(
  parameter int SECT_PER_TRK = 40,
  parameter int SECT_BYTES   = 256,
  parameter int OFF_W        = 24
) (
  input  logic [REG_W-1:0] disk_word,
  input  logic [REG_W-1:0] mult_word,
  output logic [OFF_W-1:0] offset,
  output logic [LEN_W-1:0] length
);
  logic [9:0]       trk;
  logic [5:0]       sec;
  logic [OFF_W-1:0] lin_sec;
  logic [REG_W:0]   words;

  assign trk     = disk_word[15:6];
  assign sec     = disk_word[5:0] & 6'b111110;
  assign lin_sec = OFF_W'(trk) * OFF_W'(SECT_PER_TRK) + OFF_W'(sec);
  assign offset  = OFF_W'(lin_sec * OFF_W'(SECT_BYTES));

  // negated word count -> bytes
  assign words  = (REG_W+1)'(1 << REG_W) - {1'b0, mult_word};
  assign length = {words, 1'b0};
endmodule

// File: rtl/cdc_xfer.sv
module cdc_xfer
  import cdc_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int OFF_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OFF_W-1:0]  start_off,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [MEM_AW-1:0] start_addr,
  input  logic              irq_en,
  output logic              dk_req_valid,
  input  logic              dk_req_ready,
  output logic [OFF_W-1:0]  dk_req_offset,
  output logic [LEN_W-1:0]  dk_req_len,
  input  logic              dk_dat_valid,
  output logic              dk_dat_ready,
  input  logic [7:0]        dk_dat_byte,
  input  logic              dk_err,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [MEM_AW-1:0] dma_addr,
  output logic [7:0]        dma_byte,
  output logic              busy,
  output logic              irq_pulse
);
  xfer_state_t       st_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  left_q;
  logic [MEM_AW-1:0] addr_q;
  logic              in_data;
  logic              beat;

  assign in_data = (st_q == XS_DATA);
  assign beat    = in_data && dk_dat_valid && dma_ready && !dk_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      off_q  <= '0;
      len_q  <= '0;
      left_q <= '0;
      addr_q <= '0;
    end else begin
      case (st_q)
        XS_IDLE: if (start) begin
          off_q  <= start_off;
          len_q  <= start_len;
          left_q <= start_len;
          addr_q <= start_addr;
          st_q   <= XS_REQ;
        end
        XS_REQ: if (dk_req_ready) st_q <= XS_DATA;
        XS_DATA: begin
          if (dk_err) st_q <= XS_DONE;
          else if (beat) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) st_q <= XS_DONE;
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign dk_req_valid  = (st_q == XS_REQ);
  assign dk_req_offset = off_q;
  assign dk_req_len    = len_q;
  assign dk_dat_ready  = in_data && dma_ready && !dk_err;
  assign dma_valid     = in_data && dk_dat_valid && !dk_err;
  assign dma_addr      = addr_q;
  assign dma_byte      = dk_dat_byte;
  assign busy          = (st_q != XS_IDLE);
  assign irq_pulse     = (st_q == XS_DONE) && irq_en;
endmodule

// File: rtl/cart_disk_ctrl.sv
module cart_disk_ctrl
  import cdc_pkg::*;
#(
  parameter int MEM_AW       = 16,
  parameter int SECT_PER_TRK = 40,
  parameter int SECT_BYTES   = 256,
  parameter int MAX_TRK      = 1024,
  parameter int OFF_W        = $clog2((MAX_TRK * SECT_PER_TRK + 64) * SECT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_byte,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              dk_req_valid,
  input  logic              dk_req_ready,
  output logic [OFF_W-1:0]  dk_req_offset,
  output logic [17:0]       dk_req_len,
  input  logic              dk_dat_valid,
  output logic              dk_dat_ready,
  input  logic [7:0]        dk_dat_byte,
  input  logic              dk_err,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [MEM_AW-1:0] dma_addr,
  output logic [7:0]        dma_byte,
  output logic              irq_pulse,
  output logic [2:0]        irq_level,
  output logic [8:0]        irq_vector
);
  logic [REG_W-1:0] ctrl_q, addr_q, disk_q, mult_q;
  logic             cmd_go, busy, start;
  logic [2:0]       cmd_code;
  logic [OFF_W-1:0] calc_off;
  logic [LEN_W-1:0] calc_len;
  reg_idx_t         idx;

  assign idx = reg_idx_t'(reg_addr[2:1]);

  cdc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_sel && reg_wr), .byte_en(reg_byte), .hi_lane(reg_addr[0]),
    .idx(idx), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .addr_q(addr_q), .disk_q(disk_q), .mult_q(mult_q),
    .cmd_go(cmd_go), .cmd_code(cmd_code)
  );

  cdc_geom #(.SECT_PER_TRK(SECT_PER_TRK), .SECT_BYTES(SECT_BYTES), .OFF_W(OFF_W)) u_geom (
    .disk_word(disk_q), .mult_word(mult_q), .offset(calc_off), .length(calc_len)
  );

  assign start = cmd_go && !busy &&
                 ((cmd_code == CMD_READ) || (cmd_code == CMD_READ_NH));

  cdc_xfer #(.MEM_AW(MEM_AW), .OFF_W(OFF_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_off(calc_off), .start_len(calc_len),
    .start_addr(addr_q[MEM_AW-1:0]), .irq_en(ctrl_q[6]),
    .dk_req_valid(dk_req_valid), .dk_req_ready(dk_req_ready),
    .dk_req_offset(dk_req_offset), .dk_req_len(dk_req_len),
    .dk_dat_valid(dk_dat_valid), .dk_dat_ready(dk_dat_ready),
    .dk_dat_byte(dk_dat_byte), .dk_err(dk_err),
    .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_addr(dma_addr), .dma_byte(dma_byte),
    .busy(busy), .irq_pulse(irq_pulse)
  );

  always_comb begin
    case (idx)
      RI_CTRL: reg_rdata = {ctrl_q[15:8], !busy, ctrl_q[6:1], 1'b1};
      RI_ADDR: reg_rdata = addr_q;
      RI_DISK: reg_rdata = disk_q;
      default: reg_rdata = mult_q;
    endcase
  end

  assign irq_level  = IRQ_LVL;
  assign irq_vector = IRQ_VEC;
endmodule

// File: rtl/cdc_checker.sv
module cdc_checker #(
  parameter int MEM_AW = 16,
  parameter int OFF_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        reg_addr,
  input logic [15:0]       reg_rdata,
  input logic              dk_req_valid,
  input logic              dk_req_ready,
  input logic [OFF_W-1:0]  dk_req_offset,
  input logic [17:0]       dk_req_len,
  input logic              dk_dat_valid,
  input logic              dk_dat_ready,
  input logic              dk_err,
  input logic              dma_valid,
  input logic              dma_ready,
  input logic [MEM_AW-1:0] dma_addr,
  input logic              irq_pulse
);
  // R5: pending request holds its fields
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dk_req_valid && !dk_req_ready |=> dk_req_valid && $stable(dk_req_offset) && $stable(dk_req_len));

  // R7: accepted beat advances address by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && dma_ready |=> !dma_valid || (dma_addr == MEM_AW'($past(dma_addr) + 1'b1)));

  // R7: stalled beat keeps its address
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> $stable(dma_addr));

  // R9: memory beat only when storage offers a byte
  a_r9_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> dk_dat_valid);

  // R9: storage byte consumed only when memory accepts
  a_r9_ready_sink: assert property (@(posedge clk) disable iff (!rst_n)
    dk_dat_ready |-> dma_ready);

  // R9: no data movement while request is pending
  a_r9_no_data_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    dk_req_valid |-> !dma_valid && !dk_dat_ready);

  // R10: error cycle moves nothing
  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dk_err |-> !dk_dat_ready && !dma_valid);

  // R8: controller-ready bit low while request pending
  a_r8_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dk_req_valid && (reg_addr[2:1] == 2'd0) |-> !reg_rdata[7]);

  // R11: interrupt is a single-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse && !dma_valid && !dk_req_valid);
endmodule

bind cart_disk_ctrl cdc_checker #(.MEM_AW(MEM_AW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .dk_req_valid(dk_req_valid), .dk_req_ready(dk_req_ready),
  .dk_req_offset(dk_req_offset), .dk_req_len(dk_req_len),
  .dk_dat_valid(dk_dat_valid), .dk_dat_ready(dk_dat_ready), .dk_err(dk_err),
  .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
  .irq_pulse(irq_pulse)
);

// File: tb/cart_disk_ctrl_test.sv
`timescale 1ns/1ps
module cart_disk_ctrl_test;
  localparam int AW = 8;
  localparam int OW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0, reg_byte = 0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic dk_req_valid, dk_req_ready = 0;
  logic [OW-1:0] dk_req_offset;
  logic [17:0] dk_req_len;
  logic dk_dat_valid = 0, dk_dat_ready;
  logic [7:0] dk_dat_byte = '0;
  logic dk_err = 0;
  logic dma_valid, dma_ready = 0;
  logic [AW-1:0] dma_addr;
  logic [7:0] dma_byte;
  logic irq_pulse;
  logic [2:0] irq_level;
  logic [8:0] irq_vector;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cart_disk_ctrl #(.MEM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_byte(reg_byte),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dk_req_valid(dk_req_valid), .dk_req_ready(dk_req_ready),
    .dk_req_offset(dk_req_offset), .dk_req_len(dk_req_len),
    .dk_dat_valid(dk_dat_valid), .dk_dat_ready(dk_dat_ready), .dk_dat_byte(dk_dat_byte),
    .dk_err(dk_err), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_addr(dma_addr), .dma_byte(dma_byte),
    .irq_pulse(irq_pulse), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit b);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_byte = b; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_byte = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  function automatic logic [7:0] pat(input int n, input logic [7:0] seed);
    return 8'((n * 37) + seed);
  endfunction

  task automatic run_xfer(input logic [2:0] cmd, input logic [15:0] bar, input logic [15:0] dar,
                          input logic [15:0] mpr, input bit ie, input bit stall,
                          input int err_at, input int req_delay, input bit poke);
    int len, exp_n, exp_off, n, cyc;
    bit done, e, dv, dr;
    logic [7:0] seed;
    len = (65536 - int'(mpr)) * 2;
    exp_n = (err_at >= 0) ? err_at : len;
    exp_off = ((int'(dar[15:6]) * 40) + int'(dar[5:0] & 6'h3e)) * 256;
    seed = bar[7:0] ^ dar[7:0];
    wr(3'd2, bar, 0);
    wr(3'd4, dar, 0);
    wr(3'd6, mpr, 0);
    wr(3'd0, {9'd0, ie, 2'b00, cmd, 1'b0}, 0);
    #1;
    chk(dk_req_valid == 1, "R3 executed read raises request", dk_req_valid, 1);
    chk(dk_req_offset == OW'(exp_off), "R5 request offset", dk_req_offset, exp_off);
    chk(dk_req_len == 18'(len), "R6 request length", dk_req_len, len);
    rd_chk(3'd0, {9'd0, ie, 2'b00, cmd, 1'b1}, "R8 ctrl ready low while busy");
    for (int d = 0; d < req_delay; d++) begin
      @(posedge clk); @(negedge clk); #1;
      chk(dk_req_valid && dk_req_offset == OW'(exp_off), "R5 request held", dk_req_offset, exp_off);
    end
    dk_req_ready = 1;
    @(posedge clk); @(negedge clk);
    dk_req_ready = 0;
    n = 0; cyc = 0; done = 0;
    while (!done && cyc < 4000) begin
      e  = (err_at >= 0) && (n == err_at);
      dv = stall ? (cyc % 3 != 1) : 1'b1;
      dr = stall ? (cyc % 4 != 2) : 1'b1;
      dk_err = e; dk_dat_valid = dv; dma_ready = dr; dk_dat_byte = pat(n, seed);
      reg_addr = 3'd0;
      if (poke && cyc == 1) begin
        reg_sel = 1; reg_wr = 1; reg_wdata = {9'd0, ie, 2'b00, 3'd6, 1'b0};
      end else begin
        reg_sel = 0; reg_wr = 0;
      end
      #1;
      chk(dma_valid == (dv && !e), "R9 R10 dma_valid", dma_valid, dv && !e);
      chk(dk_dat_ready == (dr && !e), "R9 R10 dk_dat_ready", dk_dat_ready, dr && !e);
      chk(reg_rdata[7] == 0, "R8 ready bit low in transfer", reg_rdata[7], 0);
      if (dv && dr && !e) begin
        chk(dma_addr == AW'(int'(bar) + n), "R7 dma address", dma_addr, AW'(int'(bar) + n));
        chk(dma_byte == pat(n, seed), "R7 dma byte", dma_byte, pat(n, seed));
        n++;
        if (n == len) done = 1;
      end
      if (e) done = 1;
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    dk_err = 0; dk_dat_valid = 0; dma_ready = 0; reg_sel = 0; reg_wr = 0;
    chk(n == exp_n, "R10 R6 beat count", n, exp_n);
    #1;
    chk(irq_pulse == ie, "R11 completion interrupt", irq_pulse, ie);
    chk(irq_level == 3'd5 && irq_vector == 9'o254, "R11 level and vector", irq_vector, 9'o254);
    @(posedge clk); @(negedge clk); #1;
    chk(irq_pulse == 0, "R11 pulse one cycle", irq_pulse, 0);
    chk(dk_req_valid == 0, "R8 idle after completion", dk_req_valid, 0);
    rd_chk(3'd0, {8'd0, 1'b1, ie, 2'b00, (poke ? 3'd6 : cmd), 1'b1}, "R1 ctrl ready after done");
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); @(negedge clk); #1;
        chk(dk_req_valid == 0, "R8 busy command ignored", dk_req_valid, 0);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] base, ex;
    logic [15:0] dar;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    rd_chk(3'd0, 16'h0081, "R1 reset ctrl");
    rd_chk(3'd2, 16'h0000, "R1 reset addr");
    rd_chk(3'd4, 16'h0000, "R1 reset disk");
    rd_chk(3'd6, 16'h0000, "R1 reset mult");
    chk(dk_req_valid == 0 && irq_pulse == 0, "R11 reset quiet", irq_pulse, 0);

    // R1 word readback
    for (int r = 1; r < 4; r++) begin
      for (int v = 0; v < 4; v++) begin
        ex = 16'(16'h1357 * (v + 1) + r * 16'h0f0f);
        wr(3'(r * 2), ex, 0);
        rd_chk(3'(r * 2), ex, "R1 word readback");
      end
    end

    // R2 byte lanes
    for (int r = 1; r < 4; r++) begin
      for (int lane = 0; lane < 2; lane++) begin
        base = 16'hA5C3;
        wr(3'(r * 2), base, 0);
        wr(3'(r * 2 + lane), 16'hEE3C, 1);
        ex = lane ? {8'h3C, base[7:0]} : {base[15:8], 8'h3C};
        rd_chk(3'(r * 2), ex, "R2 byte lane merge");
      end
    end

    // R3 execute bit set: stored, no action
    wr(3'd6, 16'h1234, 0);
    wr(3'd0, 16'h0084, 0);
    rd_chk(3'd6, 16'h1234, "R3 no-exec status keeps mult");
    wr(3'd0, 16'h008C, 0);
    #1;
    chk(dk_req_valid == 0, "R3 no-exec read gives no request", dk_req_valid, 0);
    rd_chk(3'd0, 16'h008D, "R3 no-exec word stored");

    // R12 other commands do nothing
    for (int c = 0; c < 6; c++) begin
      if (c == 2) continue;
      wr(3'd6, 16'h4321, 0);
      wr(3'd0, 16'(c << 1), 0);
      #1;
      chk(dk_req_valid == 0, "R12 no request", dk_req_valid, 0);
      rd_chk(3'd6, 16'h4321, "R12 mult unchanged");
    end

    // R4 status command clears mult
    wr(3'd6, 16'hBEEF, 0);
    wr(3'd0, 16'h0004, 0);
    rd_chk(3'd6, 16'h0000, "R4 status clears mult");
    #1;
    chk(dk_req_valid == 0, "R4 status no request", dk_req_valid, 0);

    // R5 geometry sweep with 2-byte reads, both read codes
    for (int i = 0; i < 16; i++) begin
      dar = {10'((i == 15) ? 1023 : i * 73), 6'((i == 15) ? 63 : (i * 5 + 1) % 64)};
      run_xfer((i % 2) ? 3'd7 : 3'd6, 16'(i * 3), dar, 16'hFFFF, i[0], 0, -1, i % 3, 0);
    end

    // R6 R7 R9 lengths, stalls, wrap
    run_xfer(3'd6, 16'h00F0, 16'h0345, 16'hFFF0, 1, 0, -1, 0, 0);
    run_xfer(3'd7, 16'h12F8, 16'h8001, 16'hFFF0, 0, 1, -1, 2, 0);
    run_xfer(3'd6, 16'h0040, 16'hFFFF, 16'hFF80, 1, 1, -1, 1, 0);
    // R10 early error
    run_xfer(3'd6, 16'h0010, 16'h0100, 16'hFFF0, 1, 1, 5, 0, 0);
    run_xfer(3'd7, 16'h0020, 16'h0200, 16'hFFF0, 0, 0, 0, 0, 0);
    // R8 command rewritten while busy
    run_xfer(3'd6, 16'h0030, 16'h0440, 16'hFFF8, 1, 0, -1, 0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule